// File: doc/BRIEF.md
# Halfword-to-Word Register Access Bridge

This block sits between a bus master that issues 16-bit or 32-bit accesses and a 32-bit register slave whose reads and writes have side effects, such as clear-on-read status or counters that restart when written. A 16-bit master must split each register access into two halfword transfers. Passing both halves straight through would touch the register twice. The bridge therefore makes sure each split access reaches the slave exactly once.

Both directions expect the low half first. On a write, the low half is held inside the bridge, and the slave sees one 32-bit write only when the high half arrives. On a read, the low-half access performs the single 32-bit read of the slave and keeps the upper half. The later high-half read is answered from that kept copy, without going back to the slave. Native 32-bit accesses are forwarded unchanged. Byte accesses are refused: they are answered with zero data and an error flag, and nothing is forwarded.

The control is a four-state machine:
- `ST_IDLE` accepts a request.
- `ST_WRITE` drives the downstream write strobe for one cycle.
- `ST_READ` drives the downstream read strobe for one cycle and captures the returned word.
- `ST_ACK` returns the response for one cycle.

Its transitions are:
- IDLE→WRITE for word and high-half writes.
- IDLE→READ for word and low-half reads.
- IDLE→ACK for low-half writes, high-half reads and refused accesses.
- WRITE→ACK and READ→ACK unconditionally.
- ACK→IDLE.

Top module: `hbw_bridge`

## Requirements
- R1: After reset both holding registers are zero, no strobe or acknowledge is active, and a high-half read or high-half write issued before any low half uses zero for the missing half.
- R2: A halfword write with address bit 1 equal to 0 (size code 2'b01) stores `up_wdata[15:0]` in the write-holding register and issues no downstream write.
- R3: A halfword write with address bit 1 equal to 1 issues exactly one downstream write. Its data is the new halfword in bits 31:16 and the held halfword in bits 15:0. Its address is the request address with bit 1 cleared.
- R4: A halfword read with address bit 1 equal to 0 issues exactly one downstream read. It returns the word's bits 15:0 in `up_rdata[15:0]` with bits 31:16 zero, and saves the word's bits 31:16 in the read-holding register.
- R5: A halfword read with address bit 1 equal to 1 returns the read-holding register in `up_rdata[15:0]` with zero above it, and issues no downstream read. Later slave changes do not alter the returned value.
- R6: A word write (size code 2'b10) issues one downstream write with the request's address and data unchanged.
- R7: A word read issues one downstream read at the request address and returns the full 32-bit word.
- R8: A byte access (size code 2'b00), or the unused size code 2'b11, issues no downstream access, returns zero data, and asserts `up_err` during its acknowledge cycle. Such a write leaves the write-holding register unchanged.
- R9: Every accepted request gets exactly one single-cycle acknowledge: one cycle after acceptance when nothing is forwarded, two cycles after when a strobe is issued. Downstream read and write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Request pulse, sampled only while the bridge is idle |
| up_we | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| up_addr | input | AW | Byte address; bit 1 selects the half for halfword accesses |
| up_wdata | input | 32 | Write data; halfword writes use bits 15:0 |
| up_rdata | output | 32 | Read data, valid with `up_ack` |
| up_ack | output | 1 | One-cycle completion pulse |
| up_err | output | 1 | Refused-access flag, valid with `up_ack` |
| dn_addr | output | AW | Downstream register address |
| dn_wr | output | 1 | Downstream write strobe, one cycle |
| dn_rd | output | 1 | Downstream read strobe, one cycle |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid in the cycle of `dn_rd` |

## Verification
The embedded properties check the following on every cycle:
- The acknowledge lasts exactly one cycle.
- The two downstream strobes never overlap.
- Every strobe is followed by an acknowledge.
- An error always comes with zero data.
- A combined write never points at the upper half of a word.
- A low-half read returns zero above bit 15.
- A high-half read never follows a downstream read.

Only the bench scenarios can show the following, because they depend on history across separate requests:
- The slave sees the right number of accesses.
- The held halves are combined correctly and survive intervening refused byte writes.
- A high-half read keeps returning the saved copy after the slave word has changed.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_ACK
    } hbw_state_e;

    typedef enum logic [2:0] {
        AK_WORD_WR,
        AK_WORD_RD,
        AK_LO_WR,
        AK_HI_WR,
        AK_LO_RD,
        AK_HI_RD,
        AK_BAD
    } hbw_kind_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

endpackage

// File: rtl/hbw_classify.sv
module hbw_classify
    import hbw_pkg::*;
(
    input  logic       we,
    input  logic [1:0] size,
    input  logic       half_sel,
    output hbw_kind_e  kind
);

    always_comb begin
        unique case (size)
            SZ_WORD: kind = we ? AK_WORD_WR : AK_WORD_RD;
            SZ_HALF: begin
                if (we) kind = half_sel ? AK_HI_WR : AK_LO_WR;
                else    kind = half_sel ? AK_HI_RD : AK_LO_RD;
            end
            default: kind = AK_BAD;
        endcase
    end

endmodule

// File: rtl/hbw_hold.sv
module hbw_hold #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_load,
    input  logic [HW-1:0] wr_din,
    input  logic          rd_load,
    input  logic [HW-1:0] rd_din,
    output logic [HW-1:0] wr_hold,
    output logic [HW-1:0] rd_hold
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_hold <= '0;
            rd_hold <= '0;
        end else begin
            if (wr_load) wr_hold <= wr_din;
            if (rd_load) rd_hold <= rd_din;
        end
    end

endmodule

// File: rtl/hbw_fsm.sv
module hbw_fsm
    import hbw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  hbw_kind_e  kind,
    output hbw_state_e state
);

    hbw_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    unique case (kind)
                        AK_WORD_WR, AK_HI_WR: state_nx = ST_WRITE;
                        AK_WORD_RD, AK_LO_RD: state_nx = ST_READ;
                        default:              state_nx = ST_ACK;
                    endcase
                end
            end
            ST_WRITE: state_nx = ST_ACK;
            ST_READ:  state_nx = ST_ACK;
            ST_ACK:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/hbw_bridge.sv
module hbw_bridge
    import hbw_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_req,
    input  logic          up_we,
    input  logic [1:0]    up_size,
    input  logic [AW-1:0] up_addr,
    input  logic [DW-1:0] up_wdata,
    output logic [DW-1:0] up_rdata,
    output logic          up_ack,
    output logic          up_err,
    output logic [AW-1:0] dn_addr,
    output logic          dn_wr,
    output logic          dn_rd,
    output logic [DW-1:0] dn_wdata,
    input  logic [DW-1:0] dn_rdata
);

    localparam int HW = DW / 2;

    hbw_state_e    state;
    hbw_kind_e     kind;
    hbw_kind_e     kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          err_q;
    logic [HW-1:0] wr_hold;
    logic [HW-1:0] rd_hold;
    logic          accept;

    hbw_classify u_classify (
        .we       (up_we),
        .size     (up_size),
        .half_sel (up_addr[1]),
        .kind     (kind)
    );

    hbw_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (up_req),
        .kind  (kind),
        .state (state)
    );

    assign accept = (state == ST_IDLE) && up_req;

    hbw_hold #(.HW(HW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_load (accept && (kind == AK_LO_WR)),
        .wr_din  (up_wdata[HW-1:0]),
        .rd_load ((state == ST_READ) && (kind_q == AK_LO_RD)),
        .rd_din  (dn_rdata[DW-1:HW]),
        .wr_hold (wr_hold),
        .rd_hold (rd_hold)
    );

    // Request capture and response data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= AK_BAD;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            kind_q  <= kind;
            err_q   <= (kind == AK_BAD);
            addr_q  <= up_addr;
            wdata_q <= up_wdata;
            rdata_q <= '0;
            if (kind == AK_HI_WR) begin
                addr_q     <= up_addr;
                addr_q[1]  <= 1'b0;
                wdata_q    <= {up_wdata[HW-1:0], wr_hold};
            end
            if (kind == AK_HI_RD) rdata_q <= {{HW{1'b0}}, rd_hold};
        end else if (state == ST_READ) begin
            if (kind_q == AK_LO_RD) rdata_q <= {{HW{1'b0}}, dn_rdata[HW-1:0]};
            else                    rdata_q <= dn_rdata;
        end
    end

    // Output decode
    always_comb begin
        dn_wr    = (state == ST_WRITE);
        dn_rd    = (state == ST_READ);
        dn_addr  = addr_q;
        dn_wdata = wdata_q;
        up_ack   = (state == ST_ACK);
        up_err   = up_ack && err_q;
        up_rdata = up_ack ? rdata_q : '0;
    end

    // R9
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |=> !up_ack);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_wr && dn_rd));

    // R9
    strobe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_wr || dn_rd) |=> up_ack);

    // R8
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_err |-> (up_ack && (up_rdata == '0)));

    // R3
    hi_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_wr && (kind_q == AK_HI_WR)) |-> (dn_addr[1] == 1'b0));

    // R4
    lo_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_rd && (kind_q == AK_LO_RD)) |=> (up_rdata[DW-1:HW] == '0));

    // R5
    hi_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_ack && (kind_q == AK_HI_RD)) |-> !$past(dn_rd));

endmodule

// File: tb/hbw_bridge_tb.sv
`timescale 1ns/1ps
module hbw_bridge_tb_top;

    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_req = 1'b0;
    logic          up_we = 1'b0;
    logic [1:0]    up_size = 2'b00;
    logic [AW-1:0] up_addr = '0;
    logic [DW-1:0] up_wdata = '0;
    logic [DW-1:0] up_rdata;
    logic          up_ack;
    logic          up_err;
    logic [AW-1:0] dn_addr;
    logic          dn_wr;
    logic          dn_rd;
    logic [DW-1:0] dn_wdata;
    logic [DW-1:0] dn_rdata;

    always #2.5 clk = ~clk;

    hbw_bridge #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_we(up_we),
        .up_size(up_size), .up_addr(up_addr), .up_wdata(up_wdata),
        .up_rdata(up_rdata), .up_ack(up_ack), .up_err(up_err),
        .dn_addr(dn_addr), .dn_wr(dn_wr), .dn_rd(dn_rd),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    // Slave model with access counters
    logic [DW-1:0] mem [16];
    int            rd_cnt = 0;
    int            wr_cnt = 0;
    logic [AW-1:0] last_waddr = '0;
    logic [DW-1:0] last_wdata = '0;

    assign dn_rdata = mem[dn_addr[5:2]];

    initial for (int i = 0; i < 16; i++) mem[i] = '0;

    always @(posedge clk) begin
        if (dn_wr) begin
            mem[dn_addr[5:2]] <= dn_wdata;
            wr_cnt            <= wr_cnt + 1;
            last_waddr        <= dn_addr;
            last_wdata        <= dn_wdata;
        end
        if (dn_rd) rd_cnt <= rd_cnt + 1;
    end

    int vectors = 0;
    int errors  = 0;

    typedef struct {
        logic [DW-1:0] rdata;
        logic          err;
        string         tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: compare each acknowledge against the scoreboard
    always @(negedge clk) begin
        if (rst_n && up_ack) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected ack", 64'(up_ack), 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(up_rdata == e.rdata, e.tag, 64'(up_rdata), 64'(e.rdata));
                check(up_err == e.err, e.tag, 64'(up_err), 64'(e.err));
            end
        end
    end

    // Driver
    task automatic access(input logic we, input logic [1:0] sz,
                          input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic [DW-1:0] exp_rd, input logic exp_err,
                          input int exp_lat, input string tag);
        exp_t e;
        int   lat;
        e.rdata = exp_rd;
        e.err   = exp_err;
        e.tag   = tag;
        exp_q.push_back(e);
        up_we    = we;
        up_size  = sz;
        up_addr  = a;
        up_wdata = wd;
        up_req   = 1'b1;
        @(negedge clk);
        up_req = 1'b0;
        lat = 1;
        while (!up_ack && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, {tag, " R9 latency"}, 64'(lat), 64'(exp_lat));
        @(negedge clk);
    endtask

    task automatic cnt_check(input int rd_exp, input int wr_exp, input string tag);
        check(rd_cnt == rd_exp, {tag, " reads"}, 64'(rd_cnt), 64'(rd_exp));
        check(wr_cnt == wr_exp, {tag, " writes"}, 64'(wr_cnt), 64'(wr_exp));
    endtask

    initial begin : watchdog
        #(200000 * 5);
        check(1'b0, "watchdog", 64'h0, 64'h1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!up_ack && !dn_wr && !dn_rd, "R1 idle outputs",
              64'({up_ack, dn_wr, dn_rd}), 64'h0);

        // R1 R5 high read before any low read gives zero, no slave read
        access(1'b0, 2'b01, 8'h02, '0, 32'h0, 1'b0, 1, "R1 R5 hi read after reset");
        cnt_check(0, 0, "R5 hi read");

        // R1 R3 high write with no low half held
        access(1'b1, 2'b01, 8'h06, 32'h0000ABCD, 32'h0, 1'b0, 2, "R1 R3 hi write");
        cnt_check(0, 1, "R3 hi write");
        check(last_waddr == 8'h04, "R3 addr bit1 cleared", 64'(last_waddr), 64'h04);
        check(last_wdata == 32'hABCD0000, "R1 R3 zero low half",
              64'(last_wdata), 64'hABCD0000);

        // R6 word write
        access(1'b1, 2'b10, 8'h08, 32'h12345678, 32'h0, 1'b0, 2, "R6 word write");
        cnt_check(0, 2, "R6 word write");
        check(last_waddr == 8'h08 && last_wdata == 32'h12345678, "R6 passthrough",
              64'(last_wdata), 64'h12345678);

        // R7 word read
        access(1'b0, 2'b10, 8'h08, '0, 32'h12345678, 1'b0, 2, "R7 word read");
        cnt_check(1, 2, "R7 word read");

        // R2 low write held, R3 combined on high
        access(1'b1, 2'b01, 8'h10, 32'h0000BEEF, 32'h0, 1'b0, 1, "R2 lo write");
        cnt_check(1, 2, "R2 no downstream write");
        access(1'b1, 2'b01, 8'h12, 32'h0000CAFE, 32'h0, 1'b0, 2, "R3 hi write");
        cnt_check(1, 3, "R3 one write");
        check(last_waddr == 8'h10 && last_wdata == 32'hCAFEBEEF, "R3 combined",
              64'(last_wdata), 64'hCAFEBEEF);

        // R4 low read, R5 high read from saved copy
        access(1'b0, 2'b01, 8'h10, '0, 32'h0000BEEF, 1'b0, 2, "R4 lo read");
        cnt_check(2, 3, "R4 one read");
        access(1'b0, 2'b01, 8'h12, '0, 32'h0000CAFE, 1'b0, 1, "R5 hi read");
        cnt_check(2, 3, "R5 no read");

        // R5 saved copy survives slave change
        access(1'b1, 2'b10, 8'h10, 32'h11112222, 32'h0, 1'b0, 2, "R6 overwrite");
        access(1'b0, 2'b01, 8'h12, '0, 32'h0000CAFE, 1'b0, 1, "R5 held copy");
        cnt_check(2, 4, "R5 still no read");

        // R8 byte read and write refused
        access(1'b0, 2'b00, 8'h08, '0, 32'h0, 1'b1, 1, "R8 byte read");
        access(1'b1, 2'b00, 8'h08, 32'hFFFFFFFF, 32'h0, 1'b1, 1, "R8 byte write");
        cnt_check(2, 4, "R8 no downstream access");

        // R8 byte write between halves leaves the held half intact
        access(1'b1, 2'b01, 8'h14, 32'h00001111, 32'h0, 1'b0, 1, "R2 lo write 2");
        access(1'b1, 2'b00, 8'h14, 32'h0000FFFF, 32'h0, 1'b1, 1, "R8 byte between");
        access(1'b1, 2'b01, 8'h16, 32'h00002222, 32'h0, 1'b0, 2, "R3 hi write 2");
        access(1'b0, 2'b10, 8'h14, '0, 32'h22221111, 1'b0, 2, "R8 R3 hold intact");

        // R3 earlier combined write landed in the word
        access(1'b0, 2'b10, 8'h04, '0, 32'hABCD0000, 1'b0, 2, "R3 readback");

        // R8 reserved size code
        access(1'b0, 2'b11, 8'h08, '0, 32'h0, 1'b1, 1, "R8 reserved size");
        cnt_check(4, 5, "R8 reserved no access");

        check(exp_q.size() == 0, "R9 every request acked",
              64'(exp_q.size()), 64'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule